// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets a synchronous host reach an external asynchronous 16-bit static RAM of 256K words. The host gives one word access at a time through a request/ready handshake. Each request carries a word address, write data, two byte-lane enables and a direction flag. The block then drives the memory's active-low select, write strobe, read strobe and per-lane enables in the order the memory needs. Every phase is held for a whole number of clock cycles. These counts are worked out when the design is built: each nanosecond limit, given as a parameter, is rounded up at the clock period.

A write opens with the address, the lane enables and the chip select, with the read strobe held high. The write strobe and the data drivers then turn on together. After the strobe rises, the drivers stay on for one more cycle, and only then does the block go idle. The memory's read strobe stays high for the whole write, so the memory never drives the bus while the block does. A read holds select, read strobe and lane enables for the access window. On the last edge of that window the block samples the bus into a register, forcing lanes that were not enabled to zero. It then raises a one-cycle valid strobe.

The memory bus is shown as separate data-out, data-in and drive-enable signals. The bidirectional pad sits outside this block.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, host_ready is 1, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_be_n is all ones, mem_dout_oe is 0, host_rvalid is 0 and host_rdata is 0.
- R2: host_ready is 1 only while the block is idle. A request is taken on a clock edge where host_req and host_ready are both 1. While the block is busy, host_req and every other host field are ignored.
- R3: With the default parameters (10 ns clock), a write runs as follows from the edge that accepts it. First, 1 cycle with mem_ce_n=0, mem_oe_n=1, mem_we_n=1 and mem_dout_oe=0. Next, 4 cycles with mem_we_n=0 and mem_dout_oe=1. Then 1 cycle with mem_we_n=1 and mem_dout_oe still 1. After that the block is idle.
- R4: While mem_we_n is low, mem_addr, mem_be_n and mem_dout keep the address, lane enables and data taken at acceptance, even if the host fields change.
- R5: mem_dout_oe is 1 only while mem_ce_n is 0 and mem_oe_n is 1, so the controller and the memory never drive the bus at the same time.
- R6: With the default parameters, a read holds mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dout_oe=0 for 6 cycles after the accepting edge. On the following cycle the block is idle, host_rvalid is 1 for exactly that one cycle, and host_ready is 1.
- R7: Bit 0 of host_be maps to mem_be_n[0] (active low) and data bits 7:0. Bit 1 maps to mem_be_n[1] and bits 15:8. A write changes only the enabled lanes, and a write with no lane enabled changes nothing. On a read, a lane whose enable is 0 returns 0 in host_rdata.
- R8: host_rdata keeps its value from one completed read until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request |
| host_ready | output | 1 | Block idle, request can be taken |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_be | input | BE_W | Byte-lane enables, active high |
| host_rdata | output | DATA_W | Last read data |
| host_rvalid | output | 1 | One-cycle read completion strobe |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_be_n | output | BE_W | Memory byte-lane enables, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data to the memory bus |
| mem_din | input | DATA_W | Data from the memory bus |
| mem_dout_oe | output | 1 | Controller drives the memory bus |

## Verification
The hardest case to reach is the handover between accesses. This is where a new request lands exactly on the cycle that ends the previous one, or where host fields change while a write strobe is low. The stimulus keeps host_req high across whole sequences. Right after each acceptance it flips every host field, so any leak of unregistered host values into the memory pins, or a second acceptance while busy, shows up against the reference model. Partial-lane writes followed by full-word reads cover the lane mapping. In those reads, the bench's memory model drives a filler pattern on lanes that are not enabled.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WADR = 3'd1,
    ST_WPLS = 3'd2,
    ST_WHLD = 3'd3,
    ST_WREC = 3'd4,
    ST_RACC = 3'd5
  } seq_st_e;

  // Round a nanosecond limit up to whole clock cycles; zero stays zero.
  function automatic int ns2cyc(input int ns, input int clk_ps);
    if (ns <= 0) return 0;
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_wait_ctr.sv
module asram_wait_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en  = ld | (cnt_q != '0);
  assign cnt_d   = ld ? ld_val : (cnt_q - 1'b1);
  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int SA_C  = 1,
  parameter int PW_C  = 4,
  parameter int HD_C  = 1,
  parameter int REC_C = 0,
  parameter int RD_C  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             wr,
  input  logic             expired,
  output seq_st_e          state_q,
  output seq_st_e          state_d,
  output logic             ld,
  output logic [CNT_W-1:0] ld_val,
  output logic             ready
);

  localparam logic [CNT_W-1:0] SA_L  = CNT_W'(SA_C - 1);
  localparam logic [CNT_W-1:0] PW_L  = CNT_W'(PW_C - 1);
  localparam logic [CNT_W-1:0] HD_L  = CNT_W'(HD_C - 1);
  localparam logic [CNT_W-1:0] REC_L = CNT_W'((REC_C > 0) ? REC_C - 1 : 0);
  localparam logic [CNT_W-1:0] RD_L  = CNT_W'(RD_C - 1);
  localparam bit               HAS_REC = (REC_C > 0);

  assign ready = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          ld = 1'b1;
          if (wr) begin
            state_d = ST_WADR;
            ld_val  = SA_L;
          end else begin
            state_d = ST_RACC;
            ld_val  = RD_L;
          end
        end
      end
      ST_WADR: begin
        if (expired) begin
          state_d = ST_WPLS;
          ld      = 1'b1;
          ld_val  = PW_L;
        end
      end
      ST_WPLS: begin
        if (expired) begin
          state_d = ST_WHLD;
          ld      = 1'b1;
          ld_val  = HD_L;
        end
      end
      ST_WHLD: begin
        if (expired) begin
          if (HAS_REC) begin
            state_d = ST_WREC;
            ld      = 1'b1;
            ld_val  = REC_L;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_WREC: begin
        if (expired) state_d = ST_IDLE;
      end
      ST_RACC: begin
        if (expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  seq_st_e           state_d,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [BE_W-1:0]   host_be,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [BE_W-1:0]   mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_oe
);

  logic            ce_n_d;
  logic            we_n_d;
  logic            oe_n_d;
  logic            doe_d;
  logic [BE_W-1:0] be_n_d;

  // Strobes follow the next state so every pin leaves a flop.
  always_comb begin
    ce_n_d = (state_d == ST_IDLE);
    we_n_d = (state_d != ST_WPLS);
    oe_n_d = (state_d != ST_RACC);
    doe_d  = (state_d == ST_WPLS) || (state_d == ST_WHLD);
    if (accept) begin
      be_n_d = ~host_be;
    end else if (state_d == ST_IDLE) begin
      be_n_d = '1;
    end else begin
      be_n_d = mem_be_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_dout_oe <= 1'b0;
      mem_be_n    <= '1;
    end else begin
      mem_ce_n    <= ce_n_d;
      mem_we_n    <= we_n_d;
      mem_oe_n    <= oe_n_d;
      mem_dout_oe <= doe_d;
      mem_be_n    <= be_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dout <= '0;
    end else if (accept) begin
      mem_addr <= host_addr;
      mem_dout <= host_wdata;
    end
  end

endmodule

// File: rtl/asram_rcap.sv
module asram_rcap #(
  parameter int DATA_W = 16,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [BE_W-1:0]   mem_be_n,
  input  logic [DATA_W-1:0] mem_din,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] lane_d;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_d[g*8 +: 8] = mem_be_n[g] ? 8'h00 : mem_din[g*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap) begin
      rdata <= lane_d;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int CLK_PS   = 10000,
  parameter int T_AA_NS  = 55,
  parameter int T_DOE_NS = 25,
  parameter int T_RC_NS  = 55,
  parameter int T_WC_NS  = 55,
  parameter int T_PWE_NS = 40,
  parameter int T_AW_NS  = 40,
  parameter int T_SD_NS  = 25,
  parameter int T_SA_NS  = 0,
  parameter int T_HD_NS  = 0,
  localparam int BE_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  output logic              host_ready,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [BE_W-1:0]   host_be,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [BE_W-1:0]   mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_dout_oe
);

  // Phase lengths in cycles
  localparam int SA_C  = imax(1, ns2cyc(T_SA_NS, CLK_PS));
  localparam int PW_C  = imax(imax(1, ns2cyc(T_PWE_NS, CLK_PS)),
                              imax(ns2cyc(T_SD_NS, CLK_PS),
                                   ns2cyc(T_AW_NS, CLK_PS) - SA_C));
  localparam int HD_C  = imax(1, ns2cyc(T_HD_NS, CLK_PS));
  localparam int REC_C = imax(0, ns2cyc(T_WC_NS, CLK_PS) - SA_C - PW_C - HD_C);
  localparam int RD_C  = imax(1, imax(ns2cyc(T_AA_NS, CLK_PS),
                                      imax(ns2cyc(T_DOE_NS, CLK_PS),
                                           ns2cyc(T_RC_NS, CLK_PS))));
  localparam int MAXC  = imax(imax(SA_C, PW_C), imax(imax(HD_C, REC_C), RD_C));
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  seq_st_e          state_q;
  seq_st_e          state_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             expired;
  logic             accept;
  logic             cap;

  assign accept = host_req & host_ready;
  assign cap    = (state_q == ST_RACC) & expired;

  asram_wait_ctr #(.CNT_W(CNT_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ld),
    .ld_val  (ld_val),
    .expired (expired)
  );

  asram_seq #(
    .CNT_W (CNT_W),
    .SA_C  (SA_C),
    .PW_C  (PW_C),
    .HD_C  (HD_C),
    .REC_C (REC_C),
    .RD_C  (RD_C)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (host_req),
    .wr      (host_wr),
    .expired (expired),
    .state_q (state_q),
    .state_d (state_d),
    .ld      (ld),
    .ld_val  (ld_val),
    .ready   (host_ready)
  );

  asram_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .state_d     (state_d),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_be     (host_be),
    .mem_ce_n    (mem_ce_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_be_n    (mem_be_n),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_oe (mem_dout_oe)
  );

  asram_rcap #(
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) u_rcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .mem_be_n (mem_be_n),
    .mem_din  (mem_din),
    .rdata    (host_rdata),
    .rvalid   (host_rvalid)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int BE_W     = 2,
  parameter int CLK_PS   = 10000,
  parameter int T_PWE_NS = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              host_rvalid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [BE_W-1:0]   mem_be_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_dout_oe
);

  localparam int MIN_PW = imax(1, ns2cyc(T_PWE_NS, CLK_PS));

  int we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= 0;
    end else if (!mem_we_n) begin
      we_low_cnt <= we_low_cnt + 1;
    end else begin
      we_low_cnt <= 0;
    end
  end

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_oe |-> (!mem_ce_n && mem_oe_n));

  // R3
  strobe_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dout_oe));

  // R3
  drv_linger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dout_oe);

  // R3
  drv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dout_oe && mem_we_n) |=> !mem_dout_oe);

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= MIN_PW));

  // R4
  wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_dout) && $stable(mem_be_n)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_oe && (&mem_be_n)));

  // R6
  rd_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dout_oe));

  // R6
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);

endmodule

bind asram_ctrl asram_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_ready  (host_ready),
  .host_rvalid (host_rvalid),
  .mem_ce_n    (mem_ce_n),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n),
  .mem_be_n    (mem_be_n),
  .mem_addr    (mem_addr),
  .mem_dout    (mem_dout),
  .mem_dout_oe (mem_dout_oe)
);

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        host_req;
  logic        host_ready;
  logic        host_wr;
  logic [17:0] host_addr;
  logic [15:0] host_wdata;
  logic [1:0]  host_be;
  logic [15:0] host_rdata;
  logic        host_rvalid;
  logic        mem_ce_n;
  logic        mem_we_n;
  logic        mem_oe_n;
  logic [1:0]  mem_be_n;
  logic [17:0] mem_addr;
  logic [15:0] mem_dout;
  logic [15:0] mem_din;
  logic        mem_dout_oe;

  asram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ready(host_ready),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_be(host_be), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_din(mem_din), .mem_dout_oe(mem_dout_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic        ce_n, we_n, oe_n, doe, ready, rvalid, busy, is_rd;
    logic [17:0] addr;
    logic [1:0]  be_n;
    logic [15:0] dout;
    logic [15:0] rdata;
  } exp_t;

  exp_t        exp_q[$];
  exp_t        e;
  logic [15:0] mem_q [int];
  logic [15:0] word;
  logic [15:0] last_rd = 16'h0000;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic exp_t idle_e();
    exp_t t;
    t = '{ce_n:1, we_n:1, oe_n:1, doe:0, ready:1, rvalid:0, busy:0, is_rd:0,
          addr:'0, be_n:2'b11, dout:'0, rdata:'0};
    return t;
  endfunction

  function automatic logic [15:0] mem_word(input logic [17:0] a);
    return mem_q.exists(int'(a)) ? mem_q[int'(a)] : 16'h0000;
  endfunction

  // R3: 1 address cycle, 4 strobe cycles, 1 linger cycle
  task automatic push_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    exp_t t;
    t = '{ce_n:0, we_n:1, oe_n:1, doe:0, ready:0, rvalid:0, busy:1, is_rd:0,
          addr:a, be_n:~be, dout:d, rdata:'0};
    exp_q.push_back(t);
    t.we_n = 0; t.doe = 1;
    for (int i = 0; i < 4; i++) exp_q.push_back(t);
    t.we_n = 1;
    exp_q.push_back(t);
  endtask

  // R6: 6 access cycles, then an idle cycle carrying the valid strobe
  task automatic push_read(input logic [17:0] a, input logic [1:0] be);
    exp_t t;
    logic [15:0] w;
    w = mem_word(a);
    t = '{ce_n:0, we_n:1, oe_n:0, doe:0, ready:0, rvalid:0, busy:1, is_rd:1,
          addr:a, be_n:~be, dout:'0, rdata:'0};
    for (int i = 0; i < 6; i++) exp_q.push_back(t);
    t = idle_e();
    t.rvalid = 1;
    t.rdata  = {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    exp_q.push_back(t);
  endtask

  // Memory model and cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_we_n && mem_dout_oe) begin
        word = mem_word(mem_addr);
        if (!mem_be_n[0]) word[7:0]  = mem_dout[7:0];
        if (!mem_be_n[1]) word[15:8] = mem_dout[15:8];
        mem_q[int'(mem_addr)] = word;
      end
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = idle_e();
      chk("R2", "host_ready", 32'(host_ready), 32'(e.ready));
      chk(e.is_rd ? "R6" : "R3", "mem_ce_n", 32'(mem_ce_n), 32'(e.ce_n));
      chk(e.is_rd ? "R6" : "R3", "mem_we_n", 32'(mem_we_n), 32'(e.we_n));
      chk(e.is_rd ? "R6" : "R3", "mem_oe_n", 32'(mem_oe_n), 32'(e.oe_n));
      chk("R5", "mem_dout_oe", 32'(mem_dout_oe), 32'(e.doe));
      chk("R7", "mem_be_n", 32'(mem_be_n), 32'(e.be_n));
      if (e.busy) chk("R4", "mem_addr", 32'(mem_addr), 32'(e.addr));
      if (e.doe) chk("R4", "mem_dout", 32'(mem_dout), 32'(e.dout));
      chk("R6", "host_rvalid", 32'(host_rvalid), 32'(e.rvalid));
      if (e.rvalid) begin
        chk("R7", "host_rdata", 32'(host_rdata), 32'(e.rdata));
        last_rd = e.rdata;
      end else begin
        chk("R8", "host_rdata held", 32'(host_rdata), 32'(last_rd));
      end
      if (host_req && host_ready) begin
        if (host_wr) push_write(host_addr, host_wdata, host_be);
        else push_read(host_addr, host_be);
      end
    end
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      word = mem_word(mem_addr);
      mem_din = {mem_be_n[1] ? 8'hA5 : word[15:8], mem_be_n[0] ? 8'hA5 : word[7:0]};
    end else begin
      mem_din = 16'hA5A5;
    end
  end

  // One access; host fields are scrambled right after acceptance (R2, R4)
  task automatic issue(input logic wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] be, input bit keep);
    @(posedge clk); #2;
    host_wr = wr; host_addr = a; host_wdata = d; host_be = be; host_req = 1'b1;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    @(posedge clk); #2;
    host_wr = ~wr; host_addr = ~a; host_wdata = ~d; host_be = ~be;
    if (!keep) host_req = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; host_req = 1'b0; host_wr = 1'b0;
    host_addr = '0; host_wdata = '0; host_be = '0; mem_din = 16'hA5A5;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "host_ready", 32'(host_ready), 32'd1);
    chk("R1", "mem_ce_n", 32'(mem_ce_n), 32'd1);
    chk("R1", "mem_we_n", 32'(mem_we_n), 32'd1);
    chk("R1", "mem_oe_n", 32'(mem_oe_n), 32'd1);
    chk("R1", "mem_be_n", 32'(mem_be_n), 32'd3);
    chk("R1", "mem_dout_oe", 32'(mem_dout_oe), 32'd0);
    chk("R1", "host_rvalid", 32'(host_rvalid), 32'd0);
    chk("R1", "host_rdata", 32'(host_rdata), 32'd0);
    @(posedge clk); #2; rst_n = 1'b1;
    settle();

    // R3/R6: full words at both address extremes
    issue(1'b1, 18'h00000, 16'h1234, 2'b11, 1'b0); settle();
    issue(1'b1, 18'h3FFFF, 16'hBEEF, 2'b11, 1'b0); settle();
    issue(1'b0, 18'h00000, 16'h0000, 2'b11, 1'b0); settle();
    // R7: low lane only read returns high lane as zero
    issue(1'b0, 18'h3FFFF, 16'h0000, 2'b01, 1'b0); settle();
    issue(1'b0, 18'h3FFFF, 16'h0000, 2'b10, 1'b0); settle();
    // R7: partial-lane writes leave the other lane intact
    issue(1'b1, 18'h00010, 16'hAAAA, 2'b11, 1'b0); settle();
    issue(1'b1, 18'h00010, 16'h55CC, 2'b10, 1'b0); settle();
    issue(1'b0, 18'h00010, 16'h0000, 2'b11, 1'b0); settle();
    issue(1'b1, 18'h0002A, 16'h7766, 2'b01, 1'b0); settle();
    issue(1'b0, 18'h0002A, 16'h0000, 2'b11, 1'b0); settle();
    // R7: no lane enabled writes nothing and reads zero
    issue(1'b1, 18'h00010, 16'hFFFF, 2'b00, 1'b0); settle();
    issue(1'b0, 18'h00010, 16'h0000, 2'b00, 1'b0); settle();
    issue(1'b0, 18'h00010, 16'h0000, 2'b11, 1'b0); settle();
    // R2/R4: request held high across back-to-back accesses
    issue(1'b1, 18'h12345, 16'hC3A1, 2'b11, 1'b1);
    issue(1'b0, 18'h12345, 16'h0000, 2'b11, 1'b1);
    issue(1'b0, 18'h00000, 16'h0000, 2'b11, 1'b1);
    issue(1'b1, 18'h00001, 16'h0F0F, 2'b01, 1'b1);
    issue(1'b0, 18'h00001, 16'h0000, 2'b11, 1'b0);
    // R8: read data held over idle cycles
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=busy expected=idle");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule